// File: doc/BRIEF.md
# System Tick Timer

A down-counting periodic timer of parameterised width (24 bits by default) sitting behind a small word-wide register bus. Software programs a reload value and then sets the enable bit. The counter takes the reload value and steps down by one on each selected tick. When it steps from zero it sets a sticky wrap flag, can raise a one-cycle interrupt request, and starts over from the reload value.

Each tick is either a core clock cycle or a one-cycle pulse on an external reference input; a control bit picks between them. Reading the control register reports the wrap flag and clears it in that same access. Writing the current-value register restarts the count. A reload value of zero makes the timer switch itself off at its next wrap. Bus reads are combinational, valid in the cycle the access is presented. Writes and read side effects take effect at the clock edge that ends the access.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers all read 0 and `tick_irq` is low.
- R2: The control word holds enable at bit 0, interrupt enable at bit 1, source select at bit 2 and the wrap flag at bit 16. A control write stores only bits [2:0]. Every other written bit is dropped, and the wrap flag keeps its value.
- R3: The registers sit at byte offsets 0x10 (control), 0x14 (reload), 0x18 (current) and 0x1C (calibration). Calibration always reads 10000. Any other offset reads 0, and writes to it change nothing.
- R4: The reload register keeps the low CNT_W bits of a write and reads back zero-extended.
- R5: Changing enable from 0 to 1 loads the counter from reload. The counter then drops by one per tick and wraps on the tick after it reaches 0, so wraps are reload+1 ticks apart.
- R6: With source select 1 every core clock cycle is a tick. With source select 0 only cycles with `ref_tick` high are ticks.
- R7: A wrap sets the wrap flag. If interrupt enable is 1, it also drives `tick_irq` high for exactly one cycle, starting in the cycle after the wrapping edge.
- R8: A control read returns the current wrap flag and then clears it. A wrap at the same edge wins, and the flag stays set.
- R9: If reload is 0 when a wrap occurs, the enable bit is cleared and counting stops.
- R10: A write of any value to the current-value register reloads the counter from reload and clears the wrap flag.
- R11: A control write that changes source select without turning the timer on reloads the counter from reload.
- R12: While enable is 0 the current-value register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | External reference tick, one cycle per pulse |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| tick_irq | output | 1 | One-cycle interrupt request on wrap |

## Verification
The bench builds the timer with an 8-bit counter and the default 32-bit data path. This makes a full wrap at the largest reload value (255) short enough to time exactly. It also means a reload write of all ones checks the width truncation. The external-source tests drive `ref_tick` by hand, one pulse at a time. This freezes the counter between pulses, so the flag can be checked across control writes and reads without a wrap landing in between.

// File: rtl/tick_pkg.sv
package tick_pkg;

    // register byte offsets
    localparam int OFS_CTRL   = 'h10;
    localparam int OFS_RELOAD = 'h14;
    localparam int OFS_CURR   = 'h18;
    localparam int OFS_CALIB  = 'h1C;

    // control word bit positions
    localparam int BIT_EN   = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTRL,
        REG_RELOAD,
        REG_CURR,
        REG_CALIB
    } reg_sel_e;

    typedef struct packed {
        logic src;
        logic ie;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/tick_decode.sv
module tick_decode
    import tick_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = REG_NONE;
        if (bus_sel) begin
            if      (bus_addr == ADDR_W'(OFS_CTRL))   sel = REG_CTRL;
            else if (bus_addr == ADDR_W'(OFS_RELOAD)) sel = REG_RELOAD;
            else if (bus_addr == ADDR_W'(OFS_CURR))   sel = REG_CURR;
            else if (bus_addr == ADDR_W'(OFS_CALIB))  sel = REG_CALIB;
        end
    end

endmodule

// File: rtl/tick_core.sv
module tick_core
    import tick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  reg_sel_e         sel,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic             flag,
    output logic [CNT_W-1:0] cur,
    output logic [CNT_W-1:0] reload,
    output logic             expire,
    output logic             irq
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             flag;
        logic [CNT_W-1:0] cur;
        logic [CNT_W-1:0] reload;
        logic             irq;
    } state_t;

    state_t s_d, s_q;

    logic  wr_ctrl, wr_reload, wr_curr, rd_ctrl, step;
    ctrl_t wctrl;

    always_comb begin
        wr_ctrl   = (sel == REG_CTRL)   && wr;
        wr_reload = (sel == REG_RELOAD) && wr;
        wr_curr   = (sel == REG_CURR)   && wr;
        rd_ctrl   = (sel == REG_CTRL)   && !wr;
        wctrl.en  = wdata[BIT_EN];
        wctrl.ie  = wdata[BIT_IE];
        wctrl.src = wdata[BIT_SRC];
        // register writes to control or current take the edge; no tick then
        step = s_q.ctrl.en && (s_q.ctrl.src || ref_tick) && !wr_ctrl && !wr_curr;
    end

    always_comb begin
        s_d    = s_q;
        s_d.irq = 1'b0;
        expire = 1'b0;

        // read side effect first, so a wrap at the same edge wins
        if (rd_ctrl) s_d.flag = 1'b0;

        if (step) begin
            if (s_q.cur == '0) begin
                expire   = 1'b1;
                s_d.flag = 1'b1;
                s_d.irq  = s_q.ctrl.ie;
                if (s_q.reload == '0) s_d.ctrl.en = 1'b0;
                else                  s_d.cur     = s_q.reload;
            end else begin
                s_d.cur = s_q.cur - 1'b1;
            end
        end

        if (wr_reload) s_d.reload = wdata;

        if (wr_curr) begin
            s_d.cur  = s_q.reload;
            s_d.flag = 1'b0;
        end

        if (wr_ctrl) begin
            s_d.ctrl = wctrl;
            if ((wctrl.en && !s_q.ctrl.en) || (wctrl.src != s_q.ctrl.src))
                s_d.cur = s_q.reload;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl   = s_q.ctrl;
    assign flag   = s_q.flag;
    assign cur    = s_q.cur;
    assign reload = s_q.reload;
    assign irq    = s_q.irq;

endmodule

// File: rtl/tick_rdmux.sv
module tick_rdmux
    import tick_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int DATA_W    = 32,
    parameter int CALIB_VAL = 10000
) (
    input  reg_sel_e          sel,
    input  ctrl_t             ctrl,
    input  logic              flag,
    input  logic [CNT_W-1:0]  cur,
    input  logic [CNT_W-1:0]  reload,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] ctrl_word;

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_EN]   = ctrl.en;
        ctrl_word[BIT_IE]   = ctrl.ie;
        ctrl_word[BIT_SRC]  = ctrl.src;
        ctrl_word[BIT_FLAG] = flag;
    end

    always_comb begin
        case (sel)
            REG_CTRL:   rdata = ctrl_word;
            REG_RELOAD: rdata = DATA_W'(reload);
            REG_CURR:   rdata = ctrl.en ? DATA_W'(cur) : '0;
            REG_CALIB:  rdata = DATA_W'(CALIB_VAL);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 24,
    parameter int CALIB_VAL = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);

    reg_sel_e         reg_sel;
    ctrl_t            ctrl_q;
    logic             ctrl_en;
    logic             flag_q;
    logic [CNT_W-1:0] cur_q;
    logic [CNT_W-1:0] reload_q;
    logic             expire;
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:CNT_W];
    assign ctrl_en      = ctrl_q.en;

    tick_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .sel      (reg_sel)
    );

    tick_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .sel      (reg_sel),
        .wr       (bus_wr),
        .wdata    (bus_wdata[CNT_W-1:0]),
        .ctrl     (ctrl_q),
        .flag     (flag_q),
        .cur      (cur_q),
        .reload   (reload_q),
        .expire   (expire),
        .irq      (tick_irq)
    );

    tick_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W), .CALIB_VAL(CALIB_VAL)) u_rdmux (
        .sel    (reg_sel),
        .ctrl   (ctrl_q),
        .flag   (flag_q),
        .cur    (cur_q),
        .reload (reload_q),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 24,
    parameter int CALIB_VAL = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick_irq,
    input logic              en,
    input logic              flag,
    input logic              expire,
    input logic [CNT_W-1:0]  reload
);

    logic rd_ctrl, rd_curr, rd_calib;
    assign rd_ctrl  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign rd_curr  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_CURR));
    assign rd_calib = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_CALIB));

    // R7
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |=> !tick_irq);

    // R7
    irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> flag);

    // R8
    flag_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !expire) |=> !flag);

    // R9
    zero_reload_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && (reload == '0)) |=> !en);

    // R12
    idle_curr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_curr && !en) |-> (bus_rdata == '0));

    // R3
    calib_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_calib |-> (bus_rdata == DATA_W'(CALIB_VAL)));

endmodule

bind tick_timer tick_timer_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .CALIB_VAL (CALIB_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .tick_irq  (tick_irq),
    .en        (ctrl_en),
    .flag      (flag_q),
    .expire    (expire),
    .reload    (reload_q)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 8;
    localparam int CALIB      = 10000;

    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h010;
    localparam logic [ADDR_W-1:0] A_RELOAD = 12'h014;
    localparam logic [ADDR_W-1:0] A_CURR   = 12'h018;
    localparam logic [ADDR_W-1:0] A_CALIB  = 12'h01C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_tick = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              tick_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && tick_irq) irq_cnt++;

    tick_timer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CALIB_VAL(CALIB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ref_pulse();
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic cleanup();
        logic [DATA_W-1:0] d;
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, d);
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        check("R1 irq low", {31'b0, tick_irq}, 32'h0);
        bus_read(A_CTRL, d);   check("R1 ctrl", d, 32'h0);
        bus_read(A_RELOAD, d); check("R1 reload", d, 32'h0);
        bus_read(A_CURR, d);   check("R1 curr", d, 32'h0);
        bus_read(A_CALIB, d);  check("R3 calib", d, CALIB);
    endtask

    task automatic t_core_count();
        logic [DATA_W-1:0] d;
        int snap;
        bus_write(A_RELOAD, 32'd5);
        #1 snap = irq_cnt;
        bus_write(A_CTRL, 32'h5);
        bus_read(A_CURR, d); check("R5 load then step", d, 32'd4);
        bus_read(A_CURR, d); check("R5 step R6 core", d, 32'd2);
        repeat (3) @(negedge clk);
        bus_read(A_CTRL, d); check("R7 flag set on wrap", d, 32'h0001_0005);
        bus_read(A_CTRL, d); check("R8 flag cleared by read", d, 32'h5);
        #1 check("R7 no irq with ie=0", irq_cnt - snap, 32'd0);
        cleanup();
    endtask

    task automatic t_irq_period();
        logic [DATA_W-1:0] d;
        int snap;
        bus_write(A_RELOAD, 32'd3);
        bus_write(A_CTRL, 32'h7);
        #1 snap = irq_cnt;
        repeat (40) @(negedge clk);
        #1 check("R5 R7 period reload+1", irq_cnt - snap, 32'd10);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CURR, d); check("R12 disabled curr", d, 32'h0);
        bus_read(A_CTRL, d);
        bus_write(A_RELOAD, 32'hFF);
        bus_write(A_CTRL, 32'h7);
        #1 snap = irq_cnt;
        repeat (512) @(negedge clk);
        #1 check("R5 max reload period", irq_cnt - snap, 32'd2);
        cleanup();
    endtask

    task automatic t_ref_source();
        logic [DATA_W-1:0] d;
        bus_write(A_RELOAD, 32'd2);
        bus_write(A_CTRL, 32'h1);
        repeat (10) @(negedge clk);
        bus_read(A_CURR, d); check("R6 no ref no step", d, 32'd2);
        ref_pulse();
        bus_read(A_CURR, d); check("R6 one ref step", d, 32'd1);
        ref_pulse();
        ref_pulse();
        bus_read(A_CTRL, d); check("R7 ref wrap flag", d, 32'h0001_0001);
        bus_read(A_CURR, d); check("R5 reloaded after wrap", d, 32'd2);
        cleanup();
    endtask

    task automatic t_zero_reload();
        logic [DATA_W-1:0] d;
        int snap;
        bus_write(A_RELOAD, 32'd0);
        bus_write(A_CTRL, 32'h7);
        #1 snap = irq_cnt;
        bus_read(A_CTRL, d); check("R9 enable cleared", d, 32'h0001_0006);
        repeat (10) @(negedge clk);
        #1 check("R9 R7 single irq", irq_cnt - snap, 32'd1);
        cleanup();
    endtask

    task automatic t_restart();
        logic [DATA_W-1:0] d;
        bus_write(A_RELOAD, 32'd9);
        bus_write(A_CTRL, 32'h5);
        repeat (12) @(negedge clk);
        bus_write(A_CURR, 32'hABC);
        bus_read(A_CURR, d); check("R10 restart from reload", d, 32'd8);
        bus_read(A_CTRL, d); check("R10 flag cleared", d, 32'h5);
        cleanup();
    endtask

    task automatic t_src_change();
        logic [DATA_W-1:0] d;
        bus_write(A_RELOAD, 32'd20);
        bus_write(A_CTRL, 32'h5);
        repeat (5) @(negedge clk);
        bus_write(A_CTRL, 32'h1);
        bus_read(A_CURR, d); check("R11 source change reloads", d, 32'd20);
        cleanup();
    endtask

    task automatic t_ctrl_mask();
        logic [DATA_W-1:0] d;
        bus_write(A_RELOAD, 32'd1);
        bus_write(A_CTRL, 32'h1);
        ref_pulse();
        ref_pulse();
        bus_write(A_CTRL, 32'hFFFE_FFF9);
        bus_read(A_CTRL, d); check("R2 mask keeps flag", d, 32'h0001_0001);
        bus_read(A_CTRL, d); check("R8 second read clear", d, 32'h1);
        bus_write(A_RELOAD, 32'hFFFF_FFFF);
        bus_read(A_RELOAD, d); check("R4 reload width", d, 32'hFF);
        cleanup();
    endtask

    task automatic t_unmapped();
        logic [DATA_W-1:0] d;
        bus_write(12'h020, 32'h55);
        bus_read(A_RELOAD, d); check("R3 unmapped write ignored", d, 32'hFF);
        bus_read(12'h020, d);  check("R3 unmapped read", d, 32'h0);
        bus_read(12'h000, d);  check("R3 low offset read", d, 32'h0);
        bus_read(A_CTRL, d);   check("R3 ctrl untouched", d, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_core_count();
        t_irq_period();
        t_ref_source();
        t_zero_reload();
        t_restart();
        t_src_change();
        t_ctrl_mask();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule